// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is an SPI master. A processor drives it through a single-cycle 32-bit register port with a 4-bit byte offset. The processor sets the clock mode, the divider and a chip-select line in the control word, and pushes bytes into a 16-entry transmit queue through the data port. Once the run bit is set, the shifter moves each queued byte out on the serial clock and data-out pins, MSB first. It gathers the same number of bytes from the serial input into a 16-entry receive queue, and the processor pops them through the same data port.

Each byte takes nine serial clock periods: eight data periods, then one idle period, after which the next byte follows at once. The divider counts system clocks per serial clock period. Its low bit is ignored, and zero selects the slowest rate. Two level-sensitive interrupt sources are provided. One reports that the run bit is set with nothing left to send. The other reports that the receive queue holds twelve or more bytes. A three-wire option releases the data-out pin and takes received bits from that pin instead.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control word at offset 0x0 reads 0x0004_0000 (only the TX-space flag set), all three chip-select lines are high, `sclk` is low and `irq` is low.
- R2: Offsets are: control 0x0, data 0x4, divider 0x8 and length 0xC. The divider and length hold the low 16 written bits and read them back. Control bit 8 is stored and read back with no other effect. Every other offset reads zero.
- R3: A write to offset 0x4 appends a byte to the 16-deep TX queue and is dropped when the queue is full. A read of 0x4 pops the RX queue. Every byte shifted out puts exactly one received byte into the RX queue, MSB first.
- R4: Control bit 3 (CPOL) is the idle level of `sclk`. Control bit 2 (CPHA) picks the sampling edge: the leading edge when 0, the trailing edge when 1. With data-out looped to data-in, every byte comes back unchanged in all four modes.
- R5: The `sclk` period is the divider value with bit 0 forced to 0, counted in system clocks. A value of 0 (or 1) means 65536.
- R6: Each byte spans 9 `sclk` periods: 8 pulses followed by one idle period. When another byte is queued, its first edge lands exactly 9 periods after the previous byte's first edge.
- R7: Status in the control word: bit 16 DONE (run set, TX empty, shifter idle), bit 17 RX not empty, bit 18 TX not full, bit 19 RX holds 12 or more, bit 20 RX full.
- R8: DONE rises on the cycle after the run bit (bit 7) is written with an empty TX queue. `irq` is the level (DONE and bit 9) or (RX-12 and bit 10).
- R9: No byte starts while the RX queue is full. Queued TX data waits, with `sclk` idle, until a byte is popped.
- R10: Writing control bit 4 empties the TX queue and writing bit 5 empties the RX queue. Both read back as 0.
- R11: Bits 1:0 select chip-select line 0, 1 or 2; the value 3 selects none. A line is active only while bit 7 is set. Its active level is high when bit 21+i or bit 6 is set, otherwise low. At most one line is active.
- R12: With control bit 12 set, `mosi_oe` is low and received bits are taken from `mosi_i` instead of `miso_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out pin |
| mosi_i | input | 1 | Pad input of the data-out pin (three-wire receive) |
| miso_i | input | 1 | Serial data in |
| cs_line | output | 3 | Chip-select lines, polarity per line |

## Verification
The bench loops data-out back to data-in in all four clock modes, so a sampling edge in the wrong place shows up as a shifted or corrupted byte. It timestamps `sclk` edges to catch a divider that honours bit 0, a zero divider that is not 65536, and a byte that runs without the idle period or leaves an extra gap. It fills the RX queue to make sure a design that overwrites or drops data instead of stalling is exposed. It also overfills the TX queue and confirms the seventeenth byte is dropped. Finally, it walks the chip-select encodings and polarities, and sets the three-wire bit against an opposite `miso_i` level so that reading from the wrong pin is caught.

// File: rtl/spi_fifo_master_pkg.sv
package spi_fifo_master_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WORD_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_LEN  = 4'hC;

  localparam int unsigned B_CPHA   = 2;
  localparam int unsigned B_CPOL   = 3;
  localparam int unsigned B_CLRTX  = 4;
  localparam int unsigned B_CLRRX  = 5;
  localparam int unsigned B_CSPOL  = 6;
  localparam int unsigned B_RUN    = 7;
  localparam int unsigned B_DMAEN  = 8;
  localparam int unsigned B_DONEIE = 9;
  localparam int unsigned B_RXRIE  = 10;
  localparam int unsigned B_REN    = 12;
  localparam int unsigned B_DONE   = 16;
  localparam int unsigned B_LPOL0  = 21;

  typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_GAP} sh_state_t;
endpackage

// File: rtl/spi_fifo_master_fifo.sv
module spi_fifo_master_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem_q[wp_q] <= wdata;
  end
endmodule

// File: rtl/spi_fifo_master_shifter.sv
module spi_fifo_master_shifter
  import spi_fifo_master_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned EDGES = 2 * WORD_W,
  localparam int unsigned HC_W  = $clog2(EDGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              ren,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_avail,
  input  logic              rx_room,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              miso_i,
  input  logic              mosi_i,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_byte,
  output logic              busy,
  output logic              sclk,
  output logic              mosi_o,
  output logic              mosi_oe
);
  localparam logic [DIV_W-1:0] HALF_MAX = {1'b1, {(DIV_W-1){1'b0}}};

  sh_state_t         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d, half;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [WORD_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic              sclk_q, sclk_d, bit_q, bit_d;
  logic              tick, start_ok, din;

  assign half     = (div[DIV_W-1:1] == '0) ? HALF_MAX : {1'b0, div[DIV_W-1:1]};
  assign tick     = (cnt_q == half - 1'b1);
  assign start_ok = run & tx_avail & rx_room;
  assign din      = ren ? mosi_i : miso_i;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hc_d    = hc_q;
    sh_d    = sh_q;
    rx_d    = rx_q;
    sclk_d  = sclk_q;
    bit_d   = bit_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    if (!run) begin
      st_d   = SH_IDLE;
      sclk_d = cpol;
      cnt_d  = '0;
    end else begin
      unique case (st_q)
        SH_BITS: begin
          if (tick) begin
            cnt_d  = '0;
            sclk_d = ~sclk_q;
            hc_d   = hc_q + 1'b1;
            if (hc_q[0] == cpha) begin
              rx_d = {rx_q[WORD_W-2:0], din};
            end else begin
              bit_d = cpha ? sh_q[WORD_W-1] : sh_q[WORD_W-2];
              sh_d  = sh_q << 1;
            end
            if (hc_q == HC_W'(EDGES-1)) begin
              rx_push = 1'b1;
              st_d    = SH_GAP;
              hc_d    = '0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SH_GAP: begin
          if (tick) begin
            cnt_d = '0;
            hc_d  = hc_q + 1'b1;
            if (hc_q[0]) begin
              st_d = SH_IDLE;
              if (start_ok) begin
                tx_pop = 1'b1;
                sh_d   = tx_byte;
                bit_d  = tx_byte[WORD_W-1];
                hc_d   = '0;
                st_d   = SH_BITS;
              end
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          sclk_d = cpol;
          cnt_d  = '0;
          if (start_ok) begin
            tx_pop = 1'b1;
            sh_d   = tx_byte;
            bit_d  = tx_byte[WORD_W-1];
            hc_d   = '0;
            st_d   = SH_BITS;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      hc_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hc_q   <= hc_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
    end
  end

  assign rx_byte = rx_d;
  assign busy    = (st_q != SH_IDLE);
  assign sclk    = sclk_q;
  assign mosi_o  = bit_q;
  assign mosi_oe = ~ren;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_master_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned RXR_LEVEL  = 12,
  parameter int unsigned NUM_CS     = 3,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_line
);
  logic [1:0]        csel_q, csel_d;
  logic              cpha_q, cpha_d, cpol_q, cpol_d, cspol_q, cspol_d;
  logic              ta_q, ta_d, dmaen_q, dmaen_d, doneie_q, doneie_d;
  logic              rxrie_q, rxrie_d, ren_q, ren_d;
  logic [NUM_CS-1:0] lpol_q, lpol_d, line_pol;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [LEN_W-1:0]  len_q, len_d;

  logic              wr_ctrl, clr_tx, clr_rx, tx_push, rx_pop;
  logic              tx_pop, rx_push, sh_busy;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_byte, rx_byte, rx_head;
  logic [CW-1:0]     tx_count, rx_count;
  logic              st_done, st_rxr;
  logic [4:0]        status;
  logic              unused_ok;

  assign wr_ctrl = bus_sel & bus_wr & (bus_addr == OFS_CTRL);
  assign clr_tx  = wr_ctrl & bus_wdata[B_CLRTX];
  assign clr_rx  = wr_ctrl & bus_wdata[B_CLRRX];
  assign tx_push = bus_sel & bus_wr & (bus_addr == OFS_DATA);
  assign rx_pop  = bus_sel & ~bus_wr & (bus_addr == OFS_DATA);

  always_comb begin
    {csel_d, cpha_d, cpol_d, cspol_d, ta_d} = {csel_q, cpha_q, cpol_q, cspol_q, ta_q};
    {dmaen_d, doneie_d, rxrie_d, ren_d, lpol_d} = {dmaen_q, doneie_q, rxrie_q, ren_q, lpol_q};
    div_d = div_q;
    len_d = len_q;
    if (wr_ctrl) begin
      csel_d   = bus_wdata[1:0];
      cpha_d   = bus_wdata[B_CPHA];
      cpol_d   = bus_wdata[B_CPOL];
      cspol_d  = bus_wdata[B_CSPOL];
      ta_d     = bus_wdata[B_RUN];
      dmaen_d  = bus_wdata[B_DMAEN];
      doneie_d = bus_wdata[B_DONEIE];
      rxrie_d  = bus_wdata[B_RXRIE];
      ren_d    = bus_wdata[B_REN];
      lpol_d   = bus_wdata[B_LPOL0 +: NUM_CS];
    end
    if (bus_sel && bus_wr && bus_addr == OFS_DIV) div_d = bus_wdata[DIV_W-1:0];
    if (bus_sel && bus_wr && bus_addr == OFS_LEN) len_d = bus_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {csel_q, cpha_q, cpol_q, cspol_q, ta_q} <= '0;
      {dmaen_q, doneie_q, rxrie_q, ren_q}     <= '0;
      lpol_q <= '0;
      div_q  <= '0;
      len_q  <= '0;
    end else begin
      {csel_q, cpha_q, cpol_q, cspol_q, ta_q} <= {csel_d, cpha_d, cpol_d, cspol_d, ta_d};
      {dmaen_q, doneie_q, rxrie_q, ren_q}     <= {dmaen_d, doneie_d, rxrie_d, ren_d};
      lpol_q <= lpol_d;
      div_q  <= div_d;
      len_q  <= len_d;
    end
  end

  spi_fifo_master_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(tx_push),
    .wdata(bus_wdata[WORD_W-1:0]), .pop(tx_pop), .rdata(tx_byte),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  spi_fifo_master_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_push),
    .wdata(rx_byte), .pop(rx_pop), .rdata(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  spi_fifo_master_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(ta_q), .cpol(cpol_q), .cpha(cpha_q),
    .ren(ren_q), .div(div_q), .tx_avail(~tx_empty), .rx_room(~rx_full),
    .tx_byte(tx_byte), .miso_i(miso_i), .mosi_i(mosi_i), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .busy(sh_busy), .sclk(sclk),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign line_pol[i] = lpol_q[i] | cspol_q;
    assign cs_line[i]  = (ta_q && csel_q == 2'(i)) ? line_pol[i] : ~line_pol[i];
  end

  assign st_done = ta_q & tx_empty & ~sh_busy;
  assign st_rxr  = (rx_count >= CW'(RXR_LEVEL));
  assign status  = {rx_full, st_rxr, ~tx_full, ~rx_empty, st_done};
  assign irq     = (st_done & doneie_q) | (st_rxr & rxrie_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[1:0]                  = csel_q;
        bus_rdata[B_CPHA]               = cpha_q;
        bus_rdata[B_CPOL]               = cpol_q;
        bus_rdata[B_CSPOL]              = cspol_q;
        bus_rdata[B_RUN]                = ta_q;
        bus_rdata[B_DMAEN]              = dmaen_q;
        bus_rdata[B_DONEIE]             = doneie_q;
        bus_rdata[B_RXRIE]              = rxrie_q;
        bus_rdata[B_REN]                = ren_q;
        bus_rdata[B_DONE +: 5]          = status;
        bus_rdata[B_LPOL0 +: NUM_CS]    = lpol_q;
      end
      OFS_DATA: bus_rdata[WORD_W-1:0] = rx_head;
      OFS_DIV:  bus_rdata[DIV_W-1:0]  = div_q;
      OFS_LEN:  bus_rdata[LEN_W-1:0]  = len_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign unused_ok = ^{bus_wdata, tx_count};
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CW     = 5,
  parameter int unsigned NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ta,
  input logic              cpol,
  input logic              ren,
  input logic              busy,
  input logic              sclk,
  input logic              mosi_oe,
  input logic [NUM_CS-1:0] cs_line,
  input logic [NUM_CS-1:0] pol_vec,
  input logic              tx_pop,
  input logic              tx_empty,
  input logic              rx_push,
  input logic              rx_full,
  input logic [CW-1:0]     rx_count,
  input logic              irq,
  input logic              done,
  input logic              doneie
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |-> sclk == cpol);
  assert_cs_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_line ~^ pol_vec));
  assert_cs_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ta |-> (cs_line ~^ pol_vec) == '0);
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));
  assert_three_wire_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ren |-> !mosi_oe);
  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && doneie) |-> irq);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(FIFO_DEPTH), .CW(CW), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ta(ta_q), .cpol(cpol_q), .ren(ren_q),
  .busy(sh_busy), .sclk(sclk), .mosi_oe(mosi_oe), .cs_line(cs_line),
  .pol_vec(line_pol), .tx_pop(tx_pop), .tx_empty(tx_empty),
  .rx_push(rx_push), .rx_full(rx_full), .rx_count(rx_count),
  .irq(irq), .done(st_done), .doneie(doneie_q)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  logic        clk, rst_n, bus_sel, bus_wr, mosi_i;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, sclk, mosi_o, mosi_oe;
  logic [2:0]  cs_line;
  int          checks = 0, errors = 0, cyc = 0;
  localparam int WD_LIMIT = 150000;

  spi_fifo_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_i(mosi_o), .cs_line(cs_line)
  );

  initial begin clk = 1'b0; forever #5 clk = ~clk; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    bit ok = 0;
    for (int n = 0; n < 5000 && !ok; n++) begin
      bus_read(4'h0, d);
      ok = d[16];
    end
    chk({req, " DONE reached"}, 32'(ok), 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(4'h0, d);
    chk("R1 control after reset", d, 32'h0004_0000);
    chk("R1 cs lines after reset", 32'(cs_line), 32'h7);
    chk("R1 sclk/irq after reset", {30'd0, sclk, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_write(4'h8, 32'hABCD_1234);
    bus_read(4'h8, d);  chk("R2 divider readback", d, 32'h1234);
    bus_write(4'hC, 32'h0000_BEEF);
    bus_read(4'hC, d);  chk("R2 length readback", d, 32'hBEEF);
    bus_write(4'h0, 32'h0000_0100);
    bus_read(4'h0, d);  chk("R2 dma bit stored", d & 32'h0000_01FF, 32'h100);
    bus_read(4'h2, d);  chk("R2 unmapped offset 0x2", d, 32'h0);
    bus_read(4'hE, d);  chk("R2 unmapped offset 0xE", d, 32'h0);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_done_irq;
    logic [31:0] d;
    bus_write(4'h8, 32'd2);
    bus_write(4'h0, 32'h0000_0280);
    chk("R8 irq right after run with empty TX", 32'(irq), 32'd1);
    bus_read(4'h0, d);  chk("R8 DONE flag", 32'(d[16]), 32'd1);
    bus_write(4'h4, 32'h11);
    chk("R8 irq drops with TX data", 32'(irq), 32'd0);
    wait_done("R8");
    chk("R8 irq back at end", 32'(irq), 32'd1);
    bus_read(4'h4, d);  chk("R3 byte returned", d, 32'h11);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      bus_write(4'h0, 32'h80 | (m << 2));
      bus_write(4'h4, 32'hA5);
      bus_write(4'h4, 32'h3C);
      wait_done("R4");
      chk($sformatf("R4 idle sclk mode %0d", m), 32'(sclk), 32'(m >> 1));
      bus_read(4'h4, d); chk($sformatf("R4 loopback byte0 mode %0d", m), d, 32'hA5);
      bus_read(4'h4, d); chk($sformatf("R4 loopback byte1 mode %0d", m), d, 32'h3C);
      bus_read(4'h0, d); chk($sformatf("R3 one rx per tx mode %0d", m), 32'(d[17]), 32'd0);
    end
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_timing(input logic [31:0] dv, input string req, input int exp_per);
    int rise[20];
    int k = 0;
    logic prev = 1'b0;
    bus_write(4'h8, dv);
    bus_write(4'h0, 32'h80);
    bus_write(4'h4, 32'hFF);
    bus_write(4'h4, 32'h00);
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (sclk && !prev && k < 20) begin rise[k] = cyc; k++; end
      prev = sclk;
    end
    chk({req, " rising edges for two bytes"}, 32'(k), 32'd16);
    chk({req, " sclk period"}, 32'(rise[1] - rise[0]), 32'(exp_per));
    chk("R6 idle period before next byte", 32'(rise[8] - rise[7]), 32'(2 * exp_per));
    chk("R6 byte pitch nine periods", 32'(rise[8] - rise[0]), 32'(9 * exp_per));
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic first_edge(input logic [31:0] dv, output int lat);
    lat = -1;
    bus_write(4'h8, dv);
    bus_write(4'h0, 32'h80);
    bus_write(4'h4, 32'hFF);
    for (int n = 1; n < 40000 && lat < 0; n++) begin
      @(negedge clk);
      if (sclk) lat = n;
    end
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_slowest;
    int l2, l0;
    first_edge(32'd2, l2);
    first_edge(32'd0, l0);
    chk("R5 divider 0 half period extra", 32'(l0 - l2), 32'd32767);
  endtask

  task automatic t_fifo_flags;
    logic [31:0] d;
    bus_write(4'h8, 32'd2);
    bus_write(4'h0, 32'h0000_0480);
    for (int i = 0; i < 16; i++) bus_write(4'h4, 32'(i));
    wait_done("R7");
    bus_read(4'h0, d); chk("R7 all status flags with RX full", 32'(d[20:16]), 32'h1F);
    chk("R8 RX-level irq", 32'(irq), 32'd1);
    bus_write(4'h4, 32'h77);
    repeat (60) @(negedge clk);
    chk("R9 sclk held while RX full", 32'(sclk), 32'd0);
    bus_read(4'h0, d); chk("R9 not DONE while stalled", 32'(d[16]), 32'd0);
    bus_read(4'h4, d); chk("R9 oldest byte kept", d, 32'h0);
    wait_done("R9");
    for (int i = 1; i < 6; i++) begin
      bus_read(4'h4, d); chk("R3 rx order", d, 32'(i));
    end
    bus_read(4'h0, d); chk("R7 RX-12 flag clear at 11", 32'(d[19]), 32'd0);
    chk("R8 irq clear below 12", 32'(irq), 32'd0);
    for (int i = 6; i < 16; i++) begin
      bus_read(4'h4, d); chk("R3 rx order", d, 32'(i));
    end
    bus_read(4'h4, d); chk("R9 stalled byte delivered", d, 32'h77);
    bus_read(4'h0, d); chk("R7 RX empty", 32'(d[17]), 32'd0);
    bus_write(4'h0, 32'h0000_0030);
    for (int i = 0; i < 17; i++) bus_write(4'h4, 32'h40 + i);
    bus_read(4'h0, d); chk("R7 TX full clears space flag", 32'(d[18]), 32'd0);
    bus_write(4'h0, 32'h80);
    wait_done("R3");
    for (int i = 0; i < 16; i++) begin
      bus_read(4'h4, d); chk("R3 queued byte", d, 32'h40 + i);
    end
    bus_read(4'h0, d); chk("R3 seventeenth byte dropped", 32'(d[17]), 32'd0);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    bus_write(4'h4, 32'h1); bus_write(4'h4, 32'h2); bus_write(4'h4, 32'h3);
    bus_write(4'h0, 32'h0000_0010);
    bus_read(4'h0, d); chk("R10 strobes read zero", d & 32'h30, 32'h0);
    bus_write(4'h0, 32'h80);
    bus_read(4'h0, d); chk("R10 TX emptied so DONE at once", 32'(d[16]), 32'd1);
    bus_write(4'h4, 32'h9);
    wait_done("R10");
    bus_write(4'h0, 32'h0000_00A0);
    bus_read(4'h0, d); chk("R10 RX emptied", 32'(d[17]), 32'd0);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_cs;
    bus_write(4'h0, 32'h1);  chk("R11 no line without run", 32'(cs_line), 32'h7);
    bus_write(4'h0, 32'h81); chk("R11 line 1 low", 32'(cs_line), 32'h5);
    bus_write(4'h0, 32'h82); chk("R11 line 2 low", 32'(cs_line), 32'h3);
    bus_write(4'h0, 32'h83); chk("R11 code 3 selects none", 32'(cs_line), 32'h7);
    bus_write(4'h0, 32'h0020_0081); chk("R11 per-line polarity", 32'(cs_line), 32'h4);
    bus_write(4'h0, 32'h0000_00C0); chk("R11 common polarity", 32'(cs_line), 32'h1);
    bus_write(4'h0, 32'h0000_0040); chk("R11 inactive after run cleared", 32'(cs_line), 32'h0);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  task automatic t_three_wire;
    logic [31:0] d;
    mosi_i = 1'b1;
    bus_write(4'h0, 32'h0000_1080);
    chk("R12 output released", 32'(mosi_oe), 32'd0);
    bus_write(4'h4, 32'h00);
    wait_done("R12");
    bus_read(4'h4, d); chk("R12 data from shared pin", d, 32'hFF);
    bus_write(4'h0, 32'h80);
    chk("R12 output driven when off", 32'(mosi_oe), 32'd1);
    bus_write(4'h4, 32'h5A);
    wait_done("R12");
    bus_read(4'h4, d); chk("R12 data from miso when off", d, 32'h5A);
    bus_write(4'h0, 32'h0000_0030);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; mosi_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_done_irq();
    t_modes();
    t_timing(32'd6, "R5", 6);
    t_timing(32'd7, "R5 odd divider", 6);
    t_slowest();
    t_fifo_flags();
    t_clear();
    t_cs();
    t_three_wire();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule